// File: doc/BRIEF.md
# Multi-slot work queue index tracker

This block keeps the bookkeeping for one send or receive work queue. Its ring is built from fixed 64-byte slots, and a single request may take up several slots. The block counts the requests in flight and keeps a producer index and a consumer index in units of requests. It also keeps a separate producer index in units of slots, which advances by the number of slots that each variable-length request occupies. From these it reports empty, full and the number of free request entries.

The surrounding logic pulses a produce strobe with the request length in 16-byte units, or a consume strobe, or both in the same cycle. When a receive queue is built, every accepted consume also advances a 32-bit message sequence counter. A ring request packs a queue ID, a priority flag and a producer increment into a 32-bit doorbell word. The word is issued with a one-cycle valid pulse, unless a doorbell-disable bit is set.

All outputs are registered or are decoded directly from registers. A strobe sampled at a rising edge is visible on the outputs right after that edge.

Top module: `wq_index_tracker`

## Requirements
- R1: With N = QUEUE_SIZE, `availCount` equals N-1 minus the number of requests in use. `isEmpty` is 1 exactly when none are in use. `isFull` is 1 exactly when N-1 are in use.
- R2: An accepted produce adds one request in use and advances `prodIdx` by one, going from N-1 back to 0.
- R3: An accepted consume removes one request in use and advances `consIdx` by one, going from N-1 back to 0.
- R4: An accepted produce advances `slotProdIdx` by ceil(len16/4), where len16 is the 16-byte length input, so that each 64-byte slot holds four units. When the sum reaches or passes N*SLOTS_PER_ENTRY, the stored value is the sum modulo that product.
- R5: When an accepted produce and an accepted consume fall in the same cycle, the number in use does not change, and `prodIdx`, `consIdx` and `slotProdIdx` all advance.
- R6: A produce requested while `isFull` is 1 changes no index and no count. It makes `overflowErr` 1 for exactly the following cycle.
- R7: A consume requested while `isEmpty` is 1 changes no index, no count and no sequence counter. It makes `underflowErr` 1 for exactly the following cycle. If a produce is requested in the same cycle, that produce is still accepted.
- R8: When RECV_QUEUE is 1, `msnCount` increments by one for each accepted consume. Rejected consumes leave it unchanged.
- R9: The doorbell word carries the queue ID in bits 31:15, the priority flag in bit 14 and the producer increment in bits 13:0.
- R10: A ring request sampled while the disable bit is 0 makes `dbValid` 1 for the following cycle, with `dbWord` encoded from the inputs of that request. Without a ring request, `dbValid` is 0.
- R11: `dbOffSet` sets the disable bit and `dbOffClr` clears it, with set winning when both are asserted. A ring request sampled while the bit is 1 gives no `dbValid`.
- R12: Reset clears all indices, the count, the sequence counter, the error pulses, the doorbell valid and the disable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| produceReq | input | 1 | Produce strobe |
| produceLen16 | input | LEN16_W | Request length in 16-byte units |
| consumeReq | input | 1 | Consume strobe |
| ringReq | input | 1 | Ring-doorbell strobe |
| ringPrio | input | 1 | Priority flag for the doorbell word |
| ringInc | input | 14 | Producer increment for the doorbell word |
| queueId | input | 17 | Queue ID for the doorbell word |
| dbOffSet | input | 1 | Set the doorbell-disable bit |
| dbOffClr | input | 1 | Clear the doorbell-disable bit |
| isEmpty | output | 1 | No request in use |
| isFull | output | 1 | N-1 requests in use |
| availCount | output | $clog2(QUEUE_SIZE) | Free request entries |
| prodIdx | output | $clog2(QUEUE_SIZE) | Producer index in requests |
| consIdx | output | $clog2(QUEUE_SIZE) | Consumer index in requests |
| slotProdIdx | output | $clog2(QUEUE_SIZE*SLOTS_PER_ENTRY) | Producer index in 64-byte slots |
| msnCount | output | 32 | Message sequence counter |
| dbValid | output | 1 | Doorbell write pulse |
| dbWord | output | 32 | Encoded doorbell word |
| dbDisabled | output | 1 | Current doorbell-disable bit |
| overflowErr | output | 1 | Produce-while-full pulse |
| underflowErr | output | 1 | Consume-while-empty pulse |

## Verification
The hardest case to reach is a slot index wrap that coincides with a request-index wrap during a simultaneous produce and consume on a full ring. In that case the slot sum passes the slot ring size by more than one whole slot, while the number in use must stay the same. The vector table first fills the queue, then frees one entry, and then issues a combined produce and consume whose length covers the whole slot ring. After that it drains past the consumer wrap and presses the rejected corners: a produce while full, a consume while empty, and a combined request on an empty queue.

// File: rtl/wqt_pkg.sv
package wqt_pkg;
  localparam int DB_QID_W  = 17;
  localparam int DB_INC_W  = 14;
  localparam int DB_WORD_W = 32;
  localparam int SLOT_UNITS = 4;  // 16-byte units per 64-byte slot

  typedef struct packed {
    logic doProduce;
    logic doConsume;
    logic doRing;
  } wqtStrobes_t;
endpackage

// File: rtl/wqt_ctrl.sv
module wqt_ctrl
  import wqt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        produceReq,
  input  logic        consumeReq,
  input  logic        ringReq,
  input  logic        dbOffSet,
  input  logic        dbOffClr,
  input  logic        isFull,
  input  logic        isEmpty,
  output wqtStrobes_t strobes,
  output logic        overflowErr,
  output logic        underflowErr,
  output logic        dbOff
);
  always_comb begin
    strobes.doProduce = produceReq && !isFull;
    strobes.doConsume = consumeReq && !isEmpty;
    strobes.doRing    = ringReq && !dbOff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overflowErr  <= 1'b0;
      underflowErr <= 1'b0;
      dbOff        <= 1'b0;
    end else begin
      overflowErr  <= produceReq && isFull;
      underflowErr <= consumeReq && isEmpty;
      if (dbOffSet)      dbOff <= 1'b1;
      else if (dbOffClr) dbOff <= 1'b0;
    end
  end
endmodule

// File: rtl/wqt_datapath.sv
module wqt_datapath
  import wqt_pkg::*;
#(
  parameter int QUEUE_SIZE      = 16,
  parameter int SLOTS_PER_ENTRY = 2,
  parameter int LEN16_W         = 8,
  parameter bit RECV_QUEUE      = 1'b1,
  localparam int IDX_W     = $clog2(QUEUE_SIZE),
  localparam int SLOT_RING = QUEUE_SIZE * SLOTS_PER_ENTRY,
  localparam int SLOT_W    = $clog2(SLOT_RING)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  wqtStrobes_t          strobes,
  input  logic [LEN16_W-1:0]   produceLen16,
  input  logic                 ringPrio,
  input  logic [DB_INC_W-1:0]  ringInc,
  input  logic [DB_QID_W-1:0]  queueId,
  output logic                 isEmpty,
  output logic                 isFull,
  output logic [IDX_W-1:0]     availCount,
  output logic [IDX_W-1:0]     prodIdx,
  output logic [IDX_W-1:0]     consIdx,
  output logic [SLOT_W-1:0]    slotProdIdx,
  output logic [31:0]          msnCount,
  output logic                 dbValid,
  output logic [DB_WORD_W-1:0] dbWord
);
  localparam int ADV_W = LEN16_W + 1;
  localparam int SUM_W = SLOT_W + ADV_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(QUEUE_SIZE - 1);

  logic [IDX_W-1:0] inUse;
  logic [ADV_W-1:0] slotAdv;
  logic [SUM_W-1:0] slotSum;
  logic [SLOT_W-1:0] slotNext;

  // ceil(len16 / units-per-slot)
  always_comb begin
    slotAdv = (ADV_W'(produceLen16) + ADV_W'(SLOT_UNITS - 1)) >> 2;
    slotSum = SUM_W'(slotProdIdx) + SUM_W'(slotAdv);
    if (slotSum >= SUM_W'(SLOT_RING)) slotNext = SLOT_W'(slotSum % SUM_W'(SLOT_RING));
    else                              slotNext = SLOT_W'(slotSum);
  end

  always_comb begin
    isEmpty    = (inUse == '0);
    isFull     = (inUse == LAST_IDX);
    availCount = LAST_IDX - inUse;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inUse       <= '0;
      prodIdx     <= '0;
      consIdx     <= '0;
      slotProdIdx <= '0;
    end else begin
      case ({strobes.doProduce, strobes.doConsume})
        2'b10:   inUse <= inUse + IDX_W'(1);
        2'b01:   inUse <= inUse - IDX_W'(1);
        default: inUse <= inUse;
      endcase
      if (strobes.doProduce) begin
        prodIdx     <= (prodIdx == LAST_IDX) ? '0 : prodIdx + IDX_W'(1);
        slotProdIdx <= slotNext;
      end
      if (strobes.doConsume)
        consIdx <= (consIdx == LAST_IDX) ? '0 : consIdx + IDX_W'(1);
    end
  end

  generate
    if (RECV_QUEUE) begin : g_msn
      always_ff @(posedge clk) begin
        if (!rst_n)                 msnCount <= '0;
        else if (strobes.doConsume) msnCount <= msnCount + 32'd1;
      end
    end else begin : g_no_msn
      assign msnCount = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbValid <= 1'b0;
      dbWord  <= '0;
    end else begin
      dbValid <= strobes.doRing;
      if (strobes.doRing) dbWord <= {queueId, ringPrio, ringInc};
    end
  end
endmodule

// File: rtl/wq_index_tracker.sv
module wq_index_tracker
  import wqt_pkg::*;
#(
  parameter int QUEUE_SIZE      = 16,
  parameter int SLOTS_PER_ENTRY = 2,
  parameter int LEN16_W         = 8,
  parameter bit RECV_QUEUE      = 1'b1,
  localparam int IDX_W  = $clog2(QUEUE_SIZE),
  localparam int SLOT_W = $clog2(QUEUE_SIZE * SLOTS_PER_ENTRY)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 produceReq,
  input  logic [LEN16_W-1:0]   produceLen16,
  input  logic                 consumeReq,
  input  logic                 ringReq,
  input  logic                 ringPrio,
  input  logic [13:0]          ringInc,
  input  logic [16:0]          queueId,
  input  logic                 dbOffSet,
  input  logic                 dbOffClr,
  output logic                 isEmpty,
  output logic                 isFull,
  output logic [IDX_W-1:0]     availCount,
  output logic [IDX_W-1:0]     prodIdx,
  output logic [IDX_W-1:0]     consIdx,
  output logic [SLOT_W-1:0]    slotProdIdx,
  output logic [31:0]          msnCount,
  output logic                 dbValid,
  output logic [31:0]          dbWord,
  output logic                 dbDisabled,
  output logic                 overflowErr,
  output logic                 underflowErr
);
  wqtStrobes_t strobes;

  wqt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .produceReq(produceReq), .consumeReq(consumeReq), .ringReq(ringReq),
    .dbOffSet(dbOffSet), .dbOffClr(dbOffClr),
    .isFull(isFull), .isEmpty(isEmpty),
    .strobes(strobes),
    .overflowErr(overflowErr), .underflowErr(underflowErr), .dbOff(dbDisabled)
  );

  wqt_datapath #(
    .QUEUE_SIZE(QUEUE_SIZE), .SLOTS_PER_ENTRY(SLOTS_PER_ENTRY),
    .LEN16_W(LEN16_W), .RECV_QUEUE(RECV_QUEUE)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .produceLen16(produceLen16), .ringPrio(ringPrio), .ringInc(ringInc), .queueId(queueId),
    .isEmpty(isEmpty), .isFull(isFull), .availCount(availCount),
    .prodIdx(prodIdx), .consIdx(consIdx), .slotProdIdx(slotProdIdx),
    .msnCount(msnCount), .dbValid(dbValid), .dbWord(dbWord)
  );
endmodule

// File: rtl/wqt_checker.sv
module wqt_checker #(
  parameter int QUEUE_SIZE      = 16,
  parameter int SLOTS_PER_ENTRY = 2,
  localparam int IDX_W  = $clog2(QUEUE_SIZE),
  localparam int SLOT_W = $clog2(QUEUE_SIZE * SLOTS_PER_ENTRY)
)(
  input logic              clk,
  input logic              rst_n,
  input logic              produceReq,
  input logic              consumeReq,
  input logic              ringReq,
  input logic              dbDisabled,
  input logic              isEmpty,
  input logic              isFull,
  input logic [IDX_W-1:0]  availCount,
  input logic [IDX_W-1:0]  prodIdx,
  input logic [IDX_W-1:0]  consIdx,
  input logic [SLOT_W-1:0] slotProdIdx,
  input logic              dbValid,
  input logic              overflowErr,
  input logic              underflowErr
);
  AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(isFull && isEmpty)); // R1
  AST_IDLE_KEEPS_INDICES: assert property (@(posedge clk) disable iff (!rst_n)
    (!produceReq && !consumeReq) |=> ($stable(prodIdx) && $stable(consIdx) && $stable(availCount))); // R2
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(slotProdIdx) < QUEUE_SIZE * SLOTS_PER_ENTRY); // R4
  AST_BOTH_KEEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (produceReq && consumeReq && !isFull && !isEmpty) |=> $stable(availCount)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    overflowErr |-> (prodIdx == $past(prodIdx))); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    underflowErr |-> (consIdx == $past(consIdx))); // R7
  AST_DB_NEEDS_RING: assert property (@(posedge clk) disable iff (!rst_n)
    dbValid |-> ($past(ringReq) && !$past(dbDisabled))); // R10
endmodule

bind wq_index_tracker wqt_checker #(
  .QUEUE_SIZE(QUEUE_SIZE), .SLOTS_PER_ENTRY(SLOTS_PER_ENTRY)
) chk_i (.*);

// File: tb/wq_index_tracker_tb_top.sv
module wq_index_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QS = 4;
  localparam int SPE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic produceReq = 0, consumeReq = 0, ringReq = 0, ringPrio = 0;
  logic dbOffSet = 0, dbOffClr = 0;
  logic [7:0]  produceLen16 = '0;
  logic [13:0] ringInc = '0;
  logic [16:0] queueId = '0;
  logic isEmpty, isFull, dbValid, dbDisabled, overflowErr, underflowErr;
  logic [1:0] availCount, prodIdx, consIdx;
  logic [4:0] slotProdIdx;
  logic [31:0] msnCount, dbWord;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wq_index_tracker #(.QUEUE_SIZE(QS), .SLOTS_PER_ENTRY(SPE), .LEN16_W(8), .RECV_QUEUE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .produceReq(produceReq), .produceLen16(produceLen16),
    .consumeReq(consumeReq), .ringReq(ringReq), .ringPrio(ringPrio), .ringInc(ringInc),
    .queueId(queueId), .dbOffSet(dbOffSet), .dbOffClr(dbOffClr),
    .isEmpty(isEmpty), .isFull(isFull), .availCount(availCount), .prodIdx(prodIdx),
    .consIdx(consIdx), .slotProdIdx(slotProdIdx), .msnCount(msnCount), .dbValid(dbValid),
    .dbWord(dbWord), .dbDisabled(dbDisabled), .overflowErr(overflowErr), .underflowErr(underflowErr)
  );

  // p, c, len16, prod, cons, slot, avail, ovf, unf, msn  (27 bits)
  localparam logic [26:0] VECS [0:12] = '{
    {1'b1,1'b0,8'd4 ,2'd1,2'd0,5'd1 ,2'd2,1'b0,1'b0,4'd0}, // R2 R4 adv 1
    {1'b1,1'b0,8'd20,2'd2,2'd0,5'd6 ,2'd1,1'b0,1'b0,4'd0}, // R4 adv 5
    {1'b1,1'b0,8'd1 ,2'd3,2'd0,5'd7 ,2'd0,1'b0,1'b0,4'd0}, // R1 full
    {1'b1,1'b0,8'd4 ,2'd3,2'd0,5'd7 ,2'd0,1'b1,1'b0,4'd0}, // R6 produce while full
    {1'b0,1'b1,8'd0 ,2'd3,2'd1,5'd7 ,2'd1,1'b0,1'b0,4'd1}, // R3 R8
    {1'b1,1'b1,8'd80,2'd0,2'd2,5'd7 ,2'd1,1'b0,1'b0,4'd2}, // R5 R4 wrap 27%20
    {1'b1,1'b0,8'd64,2'd1,2'd2,5'd3 ,2'd0,1'b0,1'b0,4'd2}, // R4 wrap 23%20
    {1'b0,1'b1,8'd0 ,2'd1,2'd3,5'd3 ,2'd1,1'b0,1'b0,4'd3}, // R3
    {1'b0,1'b1,8'd0 ,2'd1,2'd0,5'd3 ,2'd2,1'b0,1'b0,4'd4}, // R3 wrap
    {1'b0,1'b1,8'd0 ,2'd1,2'd1,5'd3 ,2'd3,1'b0,1'b0,4'd5}, // R1 empty
    {1'b0,1'b1,8'd0 ,2'd1,2'd1,5'd3 ,2'd3,1'b0,1'b1,4'd5}, // R7 R8 consume while empty
    {1'b1,1'b1,8'd0 ,2'd2,2'd1,5'd3 ,2'd2,1'b0,1'b1,4'd5}, // R7 produce kept, adv 0
    {1'b1,1'b0,8'd13,2'd3,2'd1,5'd7 ,2'd1,1'b0,1'b0,4'd5}  // R4 adv ceil(13/4)=4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearInputs();
    produceReq = 0; consumeReq = 0; ringReq = 0; dbOffSet = 0; dbOffClr = 0;
  endtask

  task automatic checkReset(input string tag);
    chk({tag, " prodIdx"}, 32'(prodIdx), 0);
    chk({tag, " consIdx"}, 32'(consIdx), 0);
    chk({tag, " slotProdIdx"}, 32'(slotProdIdx), 0);
    chk({tag, " msnCount"}, msnCount, 0);
    chk({tag, " availCount"}, 32'(availCount), QS-1);
    chk({tag, " isEmpty"}, 32'(isEmpty), 1);
    chk({tag, " dbValid"}, 32'(dbValid), 0);
    chk({tag, " dbDisabled"}, 32'(dbDisabled), 0);
    chk({tag, " errors"}, 32'({overflowErr, underflowErr}), 0);
  endtask

  task automatic ring(input logic [16:0] qid, input logic prio, input logic [13:0] inc);
    @(negedge clk);
    ringReq = 1; queueId = qid; ringPrio = prio; ringInc = inc;
    @(negedge clk);
    ringReq = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checkReset("R12 initial");

    for (int i = 0; i < 13; i++) begin
      logic [26:0] v;
      v = VECS[i];
      @(negedge clk);
      produceReq = v[26]; consumeReq = v[25]; produceLen16 = v[24:17];
      @(negedge clk);
      chk($sformatf("R2 vec%0d prodIdx", i), 32'(prodIdx), 32'(v[16:15]));
      chk($sformatf("R3 vec%0d consIdx", i), 32'(consIdx), 32'(v[14:13]));
      chk($sformatf("R4 vec%0d slotProdIdx", i), 32'(slotProdIdx), 32'(v[12:8]));
      chk($sformatf("R1 vec%0d availCount", i), 32'(availCount), 32'(v[7:6]));
      chk($sformatf("R1 vec%0d isFull", i), 32'(isFull), 32'(v[7:6] == 2'd0));
      chk($sformatf("R1 vec%0d isEmpty", i), 32'(isEmpty), 32'(v[7:6] == 2'(QS-1)));
      chk($sformatf("R6 vec%0d overflowErr", i), 32'(overflowErr), 32'(v[5]));
      chk($sformatf("R7 vec%0d underflowErr", i), 32'(underflowErr), 32'(v[4]));
      chk($sformatf("R8 vec%0d msnCount", i), msnCount, 32'(v[3:0]));
      clearInputs();
    end
    @(negedge clk);
    chk("R6 pulse ends", 32'(overflowErr), 0);
    chk("R7 pulse ends", 32'(underflowErr), 0);

    // doorbell encoding and pulse width
    ring(17'h1ABCD, 1'b1, 14'h2345);
    chk("R9 dbWord", dbWord, {17'h1ABCD, 1'b1, 14'h2345});
    chk("R10 dbValid pulse", 32'(dbValid), 1);
    @(negedge clk);
    chk("R10 dbValid one cycle", 32'(dbValid), 0);
    ring(17'h00001, 1'b0, 14'h3FFF);
    chk("R9 dbWord edge fields", dbWord, {17'h00001, 1'b0, 14'h3FFF});

    // disable register
    @(negedge clk); dbOffSet = 1; dbOffClr = 1;
    @(negedge clk); clearInputs();
    chk("R11 set wins", 32'(dbDisabled), 1);
    ring(17'h0F0F0, 1'b1, 14'h0001);
    chk("R11 suppressed", 32'(dbValid), 0);
    chk("R11 word kept", dbWord, {17'h00001, 1'b0, 14'h3FFF});
    @(negedge clk); dbOffClr = 1;
    @(negedge clk); clearInputs();
    chk("R11 cleared", 32'(dbDisabled), 0);
    ring(17'h0F0F0, 1'b1, 14'h0001);
    chk("R11 re-enabled", 32'(dbValid), 1);
    chk("R9 dbWord after enable", dbWord, {17'h0F0F0, 1'b1, 14'h0001});

    // mid-run reset
    @(negedge clk); dbOffSet = 1; produceReq = 1; produceLen16 = 8'd9;
    @(negedge clk); clearInputs(); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    checkReset("R12 mid-run");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule